// File: doc/BRIEF.md
# Aliased Partial-Width Register File

This block is a sixteen-entry, 64-bit general-purpose register file for a processor core. Every entry can be accessed as an 8-bit, 16-bit, 32-bit or 64-bit operand. Each access names a 3-bit register number, an index-extension bit, a size code and a high-byte select. The extension bit joins the register number to form a 4-bit entry number, so entries 8 to 15 can only be reached when it is set. The high-byte select picks bits 15:8 as a separate byte register, but only for entries 0 to 3.

There are two combinational read ports and one write port that is registered on the clock. Read data is always right-justified and zero-extended to 64 bits. A partial write merges into the addressed bits and leaves the rest of the entry alone. The exception is a 32-bit write in 64-bit mode, which clears bits 63:32. A mode input selects either 64-bit mode or a legacy mode. Legacy mode allows only entries 0 to 7 and operands of at most 32 bits.

An access the rules do not allow raises that port's error flag. A rejected write changes no state, and a rejected read returns zero.

Top module: `gpr_alias_file`

## Requirements
- R1: After reset every entry reads as zero, and asserting reset again clears all entries that were written before.
- R2: Size codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = 64-bit. A read returns the low 8, 16, 32 or 64 bits of the entry in the low bits of the read data, and every bit above the operand is zero.
- R3: The high-byte select is valid only with size code 0, extension bit 0 and register number 0 to 3. Such a read returns bits 15:8 of the entry in data bits 7:0, and such a write replaces only bits 15:8. Any other use of the high-byte select raises the port's error flag.
- R4: The entry number is the extension bit followed by the 3-bit register number (entry = ext*8 + number). A write that sets both the extension bit and the high-byte select raises wr_err and leaves every entry unchanged.
- R5: A valid 8-bit or 16-bit write replaces only the addressed bits. All other bits of the entry keep their value.
- R6: In 64-bit mode (long_mode = 1), a valid 32-bit write stores the low 32 bits of the data and clears bits 63:32 of the entry. A valid 64-bit write replaces the whole entry.
- R7: In legacy mode (long_mode = 0), any access with the extension bit set or with size code 3 raises the port's error flag, and a rejected write changes no entry. A valid 32-bit write in legacy mode keeps bits 63:32 of the entry.
- R8: A read that addresses the entry being written in the same cycle returns the value from before the write. The new value is visible from the next cycle on.
- R9: A read with its error flag raised returns all-zero data. wr_err is raised only when wr_en is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, clears all entries |
| long_mode | input | 1 | 1 = 64-bit mode, 0 = legacy mode |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Write register number |
| wr_ext | input | 1 | Write index-extension bit |
| wr_size | input | 2 | Write size code |
| wr_hi | input | 1 | Write high-byte select |
| wr_data | input | 64 | Write data, right-justified |
| wr_err | output | 1 | Write request rejected |
| ra_idx | input | 3 | Read port A register number |
| ra_ext | input | 1 | Read port A index-extension bit |
| ra_size | input | 2 | Read port A size code |
| ra_hi | input | 1 | Read port A high-byte select |
| ra_data | output | 64 | Read port A data |
| ra_err | output | 1 | Read port A request rejected |
| rb_idx | input | 3 | Read port B register number |
| rb_ext | input | 1 | Read port B index-extension bit |
| rb_size | input | 2 | Read port B size code |
| rb_hi | input | 1 | Read port B high-byte select |
| rb_data | output | 64 | Read port B data |
| rb_err | output | 1 | Read port B request rejected |

## Verification
Two functions can fall in the same cycle: a partial-width write that merges into an entry, and a read of that same entry on one or both read ports. The bench provokes this with directed cycles in which both read ports name the entry under write, sometimes through a different alias such as its high byte. It also runs a long pseudo-random stream over a small set of entries, so that such collisions happen often. A behavioural model applies each write only after the cycle's outputs have been compared. Any read that sees the new value too early, or that merges the wrong bits, shows up as a mismatch on that cycle or on the next one.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    localparam int XLEN        = 64;
    localparam int NREG        = 16;
    localparam int NUMW        = 3;
    localparam int ENTW        = $clog2(NREG);
    localparam int HIBYTE_REGS = 4;
    localparam int NPORT       = 3;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_W = 2'd1,
        SZ_D = 2'd2,
        SZ_Q = 2'd3
    } opsize_e;

    typedef struct packed {
        logic [NUMW-1:0] num;
        logic            ext;
        opsize_e         size;
        logic            hi;
    } gpr_req_t;

    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] regs;
    } gpr_state_t;
endpackage

// File: rtl/gpr_decode.sv
module gpr_decode
    import gpr_pkg::*;
(
    input  logic            long_mode,
    input  gpr_req_t        req,
    output logic [ENTW-1:0] entry,
    output logic            bad
);
    always_comb begin
        entry = ENTW'({req.ext, req.num});
        bad   = 1'b0;
        if (req.hi && (req.size != SZ_B || req.ext || int'(req.num) >= HIBYTE_REGS)) begin
            bad = 1'b1;
        end
        if (!long_mode && (req.ext || req.size == SZ_Q)) begin
            bad = 1'b1;
        end
    end
endmodule

// File: rtl/gpr_merge.sv
module gpr_merge
    import gpr_pkg::*;
(
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] wdata,
    input  opsize_e         size,
    input  logic            hi,
    input  logic            long_mode,
    output logic [XLEN-1:0] new_val
);
    always_comb begin
        unique case (size)
            SZ_B: begin
                if (hi) begin
                    new_val = {old_val[XLEN-1:16], wdata[7:0], old_val[7:0]};
                end else begin
                    new_val = {old_val[XLEN-1:8], wdata[7:0]};
                end
            end
            SZ_W: new_val = {old_val[XLEN-1:16], wdata[15:0]};
            SZ_D: begin
                if (long_mode) begin
                    new_val = {{(XLEN-32){1'b0}}, wdata[31:0]};
                end else begin
                    new_val = {old_val[XLEN-1:32], wdata[31:0]};
                end
            end
            default: new_val = wdata;
        endcase
    end
endmodule

// File: rtl/gpr_extract.sv
module gpr_extract
    import gpr_pkg::*;
(
    input  logic [XLEN-1:0] val,
    input  opsize_e         size,
    input  logic            hi,
    input  logic            bad,
    output logic [XLEN-1:0] data
);
    always_comb begin
        data = '0;
        if (!bad) begin
            unique case (size)
                SZ_B: data[7:0]  = hi ? val[15:8] : val[7:0];
                SZ_W: data[15:0] = val[15:0];
                SZ_D: data[31:0] = val[31:0];
                default: data = val;
            endcase
        end
    end
endmodule

// File: rtl/gpr_alias_file.sv
module gpr_alias_file
    import gpr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            long_mode,
    input  logic            wr_en,
    input  logic [2:0]      wr_idx,
    input  logic            wr_ext,
    input  logic [1:0]      wr_size,
    input  logic            wr_hi,
    input  logic [63:0]     wr_data,
    output logic            wr_err,
    input  logic [2:0]      ra_idx,
    input  logic            ra_ext,
    input  logic [1:0]      ra_size,
    input  logic            ra_hi,
    output logic [63:0]     ra_data,
    output logic            ra_err,
    input  logic [2:0]      rb_idx,
    input  logic            rb_ext,
    input  logic [1:0]      rb_size,
    input  logic            rb_hi,
    output logic [63:0]     rb_data,
    output logic            rb_err
);
    gpr_state_t      st_d, st_q;
    gpr_req_t        req   [NPORT];
    logic [ENTW-1:0] entry [NPORT];
    logic            bad   [NPORT];
    logic [XLEN-1:0] rdata [NPORT];
    logic [XLEN-1:0] merged;
    logic [ENTW-1:0] wr_entry;
    logic            wr_ok;

    assign req[0] = {wr_idx, wr_ext, wr_size, wr_hi};
    assign req[1] = {ra_idx, ra_ext, ra_size, ra_hi};
    assign req[2] = {rb_idx, rb_ext, rb_size, rb_hi};

    for (genvar p = 0; p < NPORT; p++) begin : g_dec
        gpr_decode u_dec (
            .long_mode (long_mode),
            .req       (req[p]),
            .entry     (entry[p]),
            .bad       (bad[p])
        );
    end

    for (genvar p = 1; p < NPORT; p++) begin : g_rd
        gpr_extract u_ext (
            .val  (st_q.regs[entry[p]]),
            .size (req[p].size),
            .hi   (req[p].hi),
            .bad  (bad[p]),
            .data (rdata[p])
        );
    end

    assign wr_entry = entry[0];
    assign wr_ok    = wr_en && !bad[0];
    assign rdata[0] = '0;

    gpr_merge u_merge (
        .old_val   (st_q.regs[wr_entry]),
        .wdata     (wr_data),
        .size      (req[0].size),
        .hi        (req[0].hi),
        .long_mode (long_mode),
        .new_val   (merged)
    );

    always_comb begin
        st_d = st_q;
        if (wr_ok) begin
            st_d.regs[wr_entry] = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_err  = wr_en && bad[0];
    assign ra_data = rdata[1];
    assign rb_data = rdata[2];
    assign ra_err  = bad[1];
    assign rb_err  = bad[2];

    // R7
    rejected_write_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> st_q == $past(st_q));

    // R5
    byte_merge_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_err && wr_size == SZ_B && !wr_hi)
        |=> st_q.regs[$past(wr_entry)][XLEN-1:8] == $past(st_q.regs[wr_entry][XLEN-1:8]));

    // R6
    dword_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_err && long_mode && wr_size == SZ_D)
        |=> st_q.regs[$past(wr_entry)][XLEN-1:32] == '0);

    // R4
    ext_hi_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ext && wr_hi) |-> wr_err);

    // R7
    legacy_qword_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !long_mode && wr_size == SZ_Q) |-> wr_err);

    // R2
    byte_read_justified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_size == SZ_B) |-> ra_data[XLEN-1:8] == '0);

    // R9
    err_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_err |-> rb_data == '0);
endmodule

// File: tb/sim_gpr_alias_file.sv
module sim_gpr_alias_file;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        long_mode = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic        wr_ext = 1'b0;
    logic [1:0]  wr_size = '0;
    logic        wr_hi = 1'b0;
    logic [63:0] wr_data = '0;
    logic        wr_err;
    logic [2:0]  ra_idx = '0;
    logic        ra_ext = 1'b0;
    logic [1:0]  ra_size = '0;
    logic        ra_hi = 1'b0;
    logic [63:0] ra_data;
    logic        ra_err;
    logic [2:0]  rb_idx = '0;
    logic        rb_ext = 1'b0;
    logic [1:0]  rb_size = '0;
    logic        rb_hi = 1'b0;
    logic [63:0] rb_data;
    logic        rb_err;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    logic [63:0] m [16];
    int unsigned seed = 32'h1234_5678;

    always #2 clk = ~clk;

    gpr_alias_file u0 (.*);

    function automatic bit m_bad(bit lm, int n, bit x, int sz, bit h);
        if (h && (sz != 0 || x || n > 3)) return 1;
        if (!lm && (x || sz == 3)) return 1;
        return 0;
    endfunction

    function automatic logic [63:0] m_read(bit lm, int n, bit x, int sz, bit h);
        logic [63:0] v;
        if (m_bad(lm, n, x, sz, h)) return 64'h0;
        v = m[x ? n + 8 : n];
        case (sz)
            0: return h ? ((v >> 8) & 64'hff) : (v & 64'hff);
            1: return v & 64'hffff;
            2: return v & 64'hffff_ffff;
            default: return v;
        endcase
    endfunction

    task automatic m_write(bit lm, int n, bit x, int sz, bit h, logic [63:0] d);
        int e;
        int sh;
        logic [63:0] mask;
        if (m_bad(lm, n, x, sz, h)) return;
        e = x ? n + 8 : n;
        if (sz == 2 && lm) begin
            m[e] = d & 64'hffff_ffff;
            return;
        end
        sh = h ? 8 : 0;
        mask = (sz == 3) ? ~64'h0 : (((64'h1 << (8 << sz)) - 64'h1) << sh);
        m[e] = (m[e] & ~mask) | ((d << sh) & mask);
    endtask

    task automatic check(string tag, string what, logic [63:0] got, logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Called at a negative edge; returns at the next negative edge.
    task automatic cyc(string tag, bit lm, bit we, int wn, bit wx, int ws, bit wh,
                       logic [63:0] wd, int an, bit ax, int as, bit ah,
                       int bn, bit bx, int bs, bit bh);
        long_mode = lm;
        wr_en = we; wr_idx = 3'(wn); wr_ext = wx; wr_size = 2'(ws); wr_hi = wh; wr_data = wd;
        ra_idx = 3'(an); ra_ext = ax; ra_size = 2'(as); ra_hi = ah;
        rb_idx = 3'(bn); rb_ext = bx; rb_size = 2'(bs); rb_hi = bh;
        #1;
        check(tag, "ra_data", ra_data, m_read(lm, an, ax, as, ah));
        check(tag, "ra_err", 64'(ra_err), 64'(m_bad(lm, an, ax, as, ah)));
        check(tag, "rb_data", rb_data, m_read(lm, bn, bx, bs, bh));
        check(tag, "rb_err", 64'(rb_err), 64'(m_bad(lm, bn, bx, bs, bh)));
        check(tag, "wr_err", 64'(wr_err), 64'(we && m_bad(lm, wn, wx, ws, wh)));
        @(posedge clk);
        if (we) m_write(lm, wn, wx, ws, wh, wd);
        @(negedge clk);
    endtask

    task automatic rd(string tag, bit lm, int an, bit ax, int as, bit ah,
                      int bn, bit bx, int bs, bit bh);
        cyc(tag, lm, 0, 0, 0, 0, 0, 64'h0, an, ax, as, ah, bn, bx, bs, bh);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 16; i++) m[i] = 64'h0;
        rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m[i] = 64'h0;
        @(negedge clk);
        do_reset();

        // R1: every entry zero after reset
        for (int i = 0; i < 8; i++) rd("R1", 1, i, 0, 3, 0, i, 1, 3, 0);

        // R6: full-width writes; R8: same-entry read sees old value
        for (int i = 0; i < 16; i++) begin
            cyc("R8", 1, 1, i % 8, i / 8, 3, 0, {8{8'(i * 17 + 3)}} ^ 64'h0f1e_2d3c_4b5a_6978,
                i % 8, i / 8, 3, 0, i % 8, i / 8, 0, 0);
            rd("R6", 1, i % 8, i / 8, 3, 0, i % 8, i / 8, 2, 0);
        end

        // R2: each size on each read port
        for (int s = 0; s < 4; s++) rd("R2", 1, 5, 0, s, 0, 2, 1, s, 0);

        // R5: byte and word merges
        cyc("R5", 1, 1, 2, 0, 0, 0, 64'hffff_ffff_ffff_ffaa, 2, 0, 3, 0, 2, 0, 0, 0);
        rd("R5", 1, 2, 0, 3, 0, 2, 0, 0, 0);
        cyc("R5", 1, 1, 1, 1, 1, 0, 64'h1234_5678_9abc_beef, 1, 1, 3, 0, 1, 1, 1, 0);
        rd("R5", 1, 1, 1, 3, 0, 1, 1, 1, 0);

        // R3: high-byte write and read, and invalid high-byte uses
        cyc("R3", 1, 1, 1, 0, 0, 1, 64'h0000_0000_0000_0055, 1, 0, 0, 1, 1, 0, 3, 0);
        rd("R3", 1, 1, 0, 0, 1, 1, 0, 3, 0);
        rd("R3", 1, 4, 0, 0, 1, 3, 0, 1, 1);
        cyc("R3", 1, 1, 5, 0, 0, 1, 64'h77, 5, 0, 3, 0, 3, 0, 2, 1);
        rd("R3", 1, 5, 0, 3, 0, 3, 0, 0, 1);

        // R4: extension bit with high-byte select
        cyc("R4", 1, 1, 0, 1, 0, 1, 64'hdead, 0, 1, 0, 1, 0, 1, 3, 0);
        rd("R4", 1, 0, 1, 3, 0, 0, 0, 3, 0);

        // R6: 32-bit write in 64-bit mode clears the upper half
        cyc("R6", 1, 1, 7, 1, 2, 0, 64'haaaa_bbbb_cccc_dddd, 7, 1, 3, 0, 7, 1, 2, 0);
        rd("R6", 1, 7, 1, 3, 0, 7, 1, 1, 0);

        // R7: legacy mode rejections and upper-half retention
        cyc("R7", 0, 1, 3, 1, 2, 0, 64'h1111, 3, 1, 2, 0, 3, 0, 3, 0);
        cyc("R7", 0, 1, 3, 0, 3, 0, 64'h2222, 3, 0, 2, 0, 3, 0, 1, 0);
        rd("R7", 1, 3, 1, 3, 0, 3, 0, 3, 0);
        cyc("R7", 0, 1, 6, 0, 2, 0, 64'h9999_9999_5555_6666, 6, 0, 2, 0, 6, 0, 1, 0);
        rd("R7", 1, 6, 0, 3, 0, 6, 0, 2, 0);

        // R9: rejected reads return zero; no wr_err without wr_en
        rd("R9", 0, 6, 0, 3, 0, 2, 1, 0, 0);
        cyc("R9", 0, 0, 2, 1, 3, 1, 64'h5, 2, 0, 1, 1, 0, 1, 2, 0);

        // R8: back-to-back writes to one entry with both ports colliding
        for (int k = 0; k < 4; k++)
            cyc("R8", 1, 1, 0, 0, k, k == 0, {8{8'(k + 8'h40)}}, 0, 0, 3, 0, 0, 0, k, 0);
        rd("R8", 1, 0, 0, 3, 0, 0, 0, 0, 1);

        // R2: pseudo-random stream over few entries for frequent collisions
        for (int t = 0; t < 2000; t++) begin
            logic [63:0] d;
            int unsigned r;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            r = seed;
            d = {seed, seed * 32'h9e37_79b9};
            cyc("R2", r[0] | r[1], r[2], int'(r[5:3]) % 4, r[6], int'(r[8:7]), r[9] & r[10], d,
                int'(r[13:11]) % 4, r[14], int'(r[16:15]), r[17] & r[18],
                int'(r[21:19]) % 4, r[22], int'(r[24:23]), r[25] & r[26]);
        end

        // R1: reset again clears everything written
        do_reset();
        for (int i = 0; i < 8; i++) rd("R1", 1, i, 0, 3, 0, i, 1, 3, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule